// File: doc/BRIEF.md
# Power-Cycle Endurance Tester

This block drives an unattended power-cycling test of a target board. While a run is active it switches a power-enable output on and off. The length of each on phase and each off phase comes from its own input. The block counts every power-on it applies. In a separate counter it records how often the target reports that it has booted, by raising an alive line while it is powered. A healthy target matches the two counts one for one. A sticky mismatch flag latches as soon as a powered phase ends without a credited boot.

The controller is a three-state machine: `ST_IDLE` (power off, waiting), `ST_ON` (target powered) and `ST_OFF` (target unpowered between cycles). The transitions are launch (`ST_IDLE`→`ST_ON`, on a start request while the cycle count is below the limit), power-down (`ST_ON`→`ST_OFF`, when the on time has elapsed), relaunch (`ST_OFF`→`ST_ON`, when the off time has elapsed and the run continues) and finish (`ST_OFF`→`ST_IDLE`, when the off time has elapsed and either the limit has been reached or a stop was requested). Both counters are wide (40 bits by default), so a run lasting weeks cannot wrap them. They hold their values across runs until they are cleared.

Top module: `pct_power_cycler`

## Requirements
- R1: After reset the power enable and busy outputs are low, both counters read zero and the mismatch flag is clear.
- R2: A start pulse in idle begins a run only when the cycle count is below the cycle limit; otherwise (a limit of zero, or a limit already reached) power stays off and busy stays low.
- R3: Each powered phase holds the power enable high for exactly on_time_i clock cycles, and each unpowered gap between two powered phases lasts exactly off_time_i cycles.
- R4: The cycle count increases by one on the clock edge that raises the power enable, and at no other time.
- R5: The alive input passes through a two-flop synchronizer and a rising-edge detector. A rising edge seen while powered increments the alive count, at most once per powered phase. Further edges in the same phase and edges while unpowered are ignored.
- R6: An alive input that is already high when power comes on, and stays high, is not counted for that phase.
- R7: With no stop request, a run ends after the off phase in which the cycle count reached the limit. The block then returns to idle with power off.
- R8: A stop pulse during a run ends it at the end of the next off phase, and no further power-on follows.
- R9: The mismatch flag sets at the end of any powered phase that credited no alive edge. It stays set through later runs until a clear.
- R10: A clear pulse zeroes both counters and the mismatch flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-run pulse |
| stop_i | input | 1 | Stop-run request pulse |
| clear_i | input | 1 | Clear counters and mismatch flag |
| on_time_i | input | TIME_W | Powered phase length in cycles |
| off_time_i | input | TIME_W | Unpowered phase length in cycles |
| cycle_limit_i | input | CNT_W | Power-on count at which a run ends |
| alive_i | input | 1 | Asynchronous boot-success signal from target |
| pwr_en_o | output | 1 | Target power enable |
| busy_o | output | 1 | Run in progress |
| cycle_cnt_o | output | CNT_W | Applied power-on count |
| alive_cnt_o | output | CNT_W | Credited alive count |
| mismatch_o | output | 1 | Sticky boot-failure flag |

## Verification
The power enable and the cycle count change on the same edge that enters the powered state. The alive count moves on the third rising edge after alive_i rises: two synchronizer flops, then the edge register. The mismatch flag sets on the edge that ends the powered phase. The bench drives inputs and samples outputs on falling edges. It raises alive no later than the second powered sample, so that the credit lands well inside phases of eight or more cycles. It measures phase lengths by counting powered and unpowered samples, and checks counts and the flag only once busy has dropped, when every pending update has settled.

// File: rtl/pct_pkg.sv
package pct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2
    } pct_state_e;
endpackage

// File: rtl/pct_alive_edge.sv
// Synchronizes the target's alive line and flags its rising edge.
module pct_alive_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
    end

    generate
        for (genvar g = 1; g <= LAST; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/pct_phase_timer.sv
// Loadable down-counter; done_o marks the last cycle of a phase.
module pct_phase_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            left_q <= ONE;
        else if (load_i)       left_q <= (val_i == '0) ? ONE : val_i;
        else if (left_q > ONE) left_q <= left_q - ONE;
    end

    assign done_o = (left_q <= ONE);
endmodule

// File: rtl/pct_counter.sv
// Wide event counter with synchronous clear taking priority.
module pct_counter #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + W'(1);
    end
endmodule

// File: rtl/pct_power_cycler.sv
module pct_power_cycler
    import pct_pkg::*;
#(
    parameter int CNT_W       = 40,
    parameter int TIME_W      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              clear_i,
    input  logic [TIME_W-1:0] on_time_i,
    input  logic [TIME_W-1:0] off_time_i,
    input  logic [CNT_W-1:0]  cycle_limit_i,
    input  logic              alive_i,
    output logic              pwr_en_o,
    output logic              busy_o,
    output logic [CNT_W-1:0]  cycle_cnt_o,
    output logic [CNT_W-1:0]  alive_cnt_o,
    output logic              mismatch_o
);
    pct_state_e        state_q, state_d;
    logic              phase_done;
    logic              alive_rise;
    logic              credited_q;
    logic              stop_q;
    logic              tmr_load;
    logic [TIME_W-1:0] tmr_val;
    logic              cyc_inc;
    logic              alive_inc;
    logic              below_limit;

    pct_alive_edge #(.STAGES(SYNC_STAGES)) u_alive (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (alive_i),
        .rise_o  (alive_rise)
    );

    pct_phase_timer #(.W(TIME_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .done_o (phase_done)
    );

    pct_counter #(.W(CNT_W)) u_cyc_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clear_i),
        .inc_i (cyc_inc),
        .cnt_o (cycle_cnt_o)
    );

    pct_counter #(.W(CNT_W)) u_alive_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clear_i),
        .inc_i (alive_inc),
        .cnt_o (alive_cnt_o)
    );

    assign below_limit = (cycle_cnt_o < cycle_limit_i);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i && below_limit) state_d = ST_ON;     // launch
            ST_ON:   if (phase_done)             state_d = ST_OFF;    // power-down
            ST_OFF:  if (phase_done) begin
                         if (stop_q || stop_i || !below_limit)
                             state_d = ST_IDLE;                       // finish
                         else
                             state_d = ST_ON;                         // relaunch
                     end
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_load  = (state_d != state_q) && (state_d != ST_IDLE);
    assign tmr_val   = (state_d == ST_ON) ? on_time_i : off_time_i;
    assign cyc_inc   = (state_d == ST_ON) && (state_q != ST_ON);
    assign alive_inc = (state_q == ST_ON) && alive_rise && !credited_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-run and per-phase flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            credited_q <= 1'b0;
            stop_q     <= 1'b0;
            mismatch_o <= 1'b0;
        end else begin
            if (cyc_inc)        credited_q <= 1'b0;
            else if (alive_inc) credited_q <= 1'b1;

            if (state_q == ST_IDLE) stop_q <= 1'b0;
            else if (stop_i)        stop_q <= 1'b1;

            if (clear_i)
                mismatch_o <= 1'b0;
            else if (state_q == ST_ON && phase_done && !credited_q && !alive_inc)
                mismatch_o <= 1'b1;
        end
    end

    // outputs decoded from the state register
    always_comb begin
        pwr_en_o = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: busy_o   = 1'b0;
            ST_ON:   pwr_en_o = 1'b1;
            ST_OFF:  pwr_en_o = 1'b0;
            default: busy_o   = 1'b0;
        endcase
    end
endmodule

// File: rtl/pct_power_cycler_chk.sv
module pct_power_cycler_chk #(
    parameter int CNT_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             pwr_en_o,
    input logic             busy_o,
    input logic [CNT_W-1:0] cycle_cnt_o,
    input logic [CNT_W-1:0] alive_cnt_o,
    input logic             mismatch_o
);
    // R4
    cyc_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwr_en_o) && !$past(clear_i)) |-> (cycle_cnt_o == $past(cycle_cnt_o) + CNT_W'(1)));

    // R4
    cyc_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(pwr_en_o) && !$past(clear_i)) |-> $stable(cycle_cnt_o));

    // R5
    alive_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(alive_cnt_o) && !$past(clear_i)) |->
            ((alive_cnt_o == $past(alive_cnt_o) + CNT_W'(1)) && $past(pwr_en_o)));

    // R5
    alive_le_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alive_cnt_o <= cycle_cnt_o);

    // R9
    mismatch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch_o && !clear_i) |=> mismatch_o);

    // R7
    idle_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !pwr_en_o);
endmodule

bind pct_power_cycler pct_power_cycler_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .pwr_en_o    (pwr_en_o),
    .busy_o      (busy_o),
    .cycle_cnt_o (cycle_cnt_o),
    .alive_cnt_o (alive_cnt_o),
    .mismatch_o  (mismatch_o)
);

// File: tb/pct_power_cycler_bench.sv
`timescale 1ns/1ps
module pct_power_cycler_bench;
    localparam int CNT_W  = 40;
    localparam int TIME_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0, stop_i = 1'b0, clear_i = 1'b0, alive_i = 1'b0;
    logic [TIME_W-1:0] on_time_i = '0, off_time_i = '0;
    logic [CNT_W-1:0]  cycle_limit_i = '0;
    logic              pwr_en_o, busy_o, mismatch_o;
    logic [CNT_W-1:0]  cycle_cnt_o, alive_cnt_o;

    int errors = 0, checks = 0;
    bit finished = 0;
    longint m_cyc = 0, m_alive = 0;
    bit m_mis = 0;

    always #2 clk = ~clk;

    pct_power_cycler #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_pct_power_cycler (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .clear_i(clear_i),
        .on_time_i(on_time_i), .off_time_i(off_time_i), .cycle_limit_i(cycle_limit_i),
        .alive_i(alive_i), .pwr_en_o(pwr_en_o), .busy_o(busy_o),
        .cycle_cnt_o(cycle_cnt_o), .alive_cnt_o(alive_cnt_o), .mismatch_o(mismatch_o)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pick(int fmode);
        if (fmode >= 0) return fmode;
        return int'($urandom % 4);
    endfunction

    // modes: 0 boots once, 1 never boots, 2 boots with a second pulse, 3 alive stuck high
    task automatic do_run(int on_t, int off_t, longint lim, int stop_at, int fmode);
        int periods = 0, pos = 0, onc = 0, offc = 0, bad_on = 0, bad_off = 0, mode;
        bit prev = 0, seen_off = 0;
        longint cyc_before = m_cyc;
        on_time_i = TIME_W'(on_t);
        off_time_i = TIME_W'(off_t);
        cycle_limit_i = CNT_W'(lim);
        mode = pick(fmode);
        alive_i = (mode == 3);
        repeat (6) @(negedge clk);
        start_i = 1'b1;
        for (int it = 0; it < 100000; it++) begin
            bit p;
            @(negedge clk);
            start_i = 1'b0;
            p = pwr_en_o;
            if (p && !prev) begin
                periods++; pos = 0; onc = 0;
                if (seen_off && offc != off_t) bad_off++;
            end
            if (p) begin
                onc++; pos++;
                unique case (mode)
                    0: alive_i = (pos == 2 || pos == 3);
                    1: alive_i = 1'b0;
                    2: alive_i = (pos == 2 || pos == 3 || pos == 6 || pos == 7);
                    default: alive_i = 1'b1;
                endcase
            end
            if (!p && prev) begin
                if (onc != on_t) bad_on++;
                if (mode == 0 || mode == 2) m_alive++;
                else m_mis = 1;
                mode = pick(fmode);
                alive_i = (mode == 3);
                offc = 0; seen_off = 1;
            end
            if (!p) offc++;
            stop_i = (stop_at != 0 && periods == stop_at && p && pos == 1);
            prev = p;
            if (!busy_o) break;
        end
        stop_i = 1'b0;
        alive_i = 1'b0;
        repeat (6) @(negedge clk);
        m_cyc += periods;
        chk(bad_on == 0, "R3 on length", bad_on, 0);
        chk(bad_off == 0, "R3 off length", bad_off, 0);
        if (stop_at != 0)
            chk(periods == stop_at, "R8 periods after stop", periods, stop_at);
        else if (lim > cyc_before)
            chk(periods == lim - cyc_before, "R7 periods to limit", periods, lim - cyc_before);
        else
            chk(periods == 0, "R2 start ignored at limit", periods, 0);
        chk(cycle_cnt_o == CNT_W'(m_cyc), "R4 cycle count", longint'(cycle_cnt_o), m_cyc);
        chk(alive_cnt_o == CNT_W'(m_alive), "R5 alive count", longint'(alive_cnt_o), m_alive);
        chk(mismatch_o == m_mis, "R9 mismatch flag", longint'(mismatch_o), longint'(m_mis));
        chk(!pwr_en_o && !busy_o, "R7 idle after run", longint'(pwr_en_o), 0);
    endtask

    task automatic do_clear();
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        m_cyc = 0; m_alive = 0; m_mis = 0;
        chk(cycle_cnt_o == '0 && alive_cnt_o == '0, "R10 counters cleared",
            longint'(cycle_cnt_o) + longint'(alive_cnt_o), 0);
        chk(!mismatch_o, "R10 mismatch cleared", longint'(mismatch_o), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!pwr_en_o && !busy_o, "R1 reset outputs", longint'(pwr_en_o) + longint'(busy_o), 0);
        chk(cycle_cnt_o == '0 && alive_cnt_o == '0 && !mismatch_o, "R1 reset counters",
            longint'(cycle_cnt_o) + longint'(alive_cnt_o) + longint'(mismatch_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: limit of zero
        do_run(10, 8, 0, 0, 0);
        // healthy target, smallest comfortable times
        do_run(8, 6, 3, 0, 0);
        // R5: double pulse credited once
        do_run(12, 7, 5, 0, 2);
        chk(!mismatch_o, "R5 no mismatch on healthy runs", longint'(mismatch_o), 0);
        // R2: limit already reached
        do_run(12, 7, 5, 0, 0);
        // R6: stuck-high alive never credited
        do_run(10, 8, 7, 0, 3);
        // R9: flag survives a healthy run
        do_run(9, 6, 9, 0, 0);
        chk(mismatch_o, "R9 sticky across healthy run", longint'(mismatch_o), 1);
        do_clear();
        // R8: stop in the second period of a long run
        do_run(10, 9, 50, 2, 0);
        // R1..R10 random mix
        for (int r = 0; r < 6; r++) begin
            int on_t = 8 + int'($urandom % 20);
            int off_t = 6 + int'($urandom % 12);
            longint lim = m_cyc + 1 + longint'($urandom % 8);
            int st = (r == 3) ? 2 : 0;
            do_run(on_t, off_t, lim, st, -1);
            if (r == 2) do_clear();
        end
        // R1 unaffected behaviour: idle stays unpowered with no start
        repeat (20) @(negedge clk);
        chk(!pwr_en_o, "R2 idle without start", longint'(pwr_en_o), 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule